// File: doc/BRIEF.md
# Store Address Generation and Data Memory Write Path

This block carries store instructions whose operands are already resolved through the last two steps of a small in-order machine. An incoming store names a data register and brings the low address bits of its base register value and of its immediate offset. In the same cycle the block forms the effective address as their sum, keeps only the low four bits so that it falls in a 16-word data memory, and places a (data register, address) entry in a short program-order queue.

In the following cycle the oldest queued entry fires the store step. The block drives the entry's register name to a register file read port, takes the returned value, and writes it into its own data memory at the queued address. The value is read when the store fires and does not travel with the address, so a register update that lands between the two steps is the one stored. A test port returns any memory word combinationally, for checks after a run.

Top module: `store_addr_path`

## Requirements
- R1: After reset every data memory word reads 0 and no memory write is signalled (`mem_we` low).
- R2: The write address equals (`st_base` + `st_imm`) modulo 16, that is the low four bits of the sum.
- R3: The register named by `st_dreg` is presented on `rf_raddr` in the store step, and the memory receives the `rf_rdata` value present in that cycle, not a value from the acceptance cycle.
- R4: A store presented with `st_valid` high in one cycle is written in the next cycle: `mem_we` is high in that cycle and the memory word changes at its closing clock edge.
- R5: Stores leave the queue in program order, so of two stores to the same address the later one's value remains.
- R6: A cycle with `st_valid` low accepts nothing, whatever the other store inputs hold; the following cycle shows no write and memory is unchanged.
- R7: At most one memory word is written per cycle, and only when a queued entry is present.
- R8: `dbg_data` returns the word at `dbg_addr` in the same cycle, for each of the 16 addresses.
- R9: A new store is accepted in the same cycle as the previous one is written, so a back-to-back stream sustains one store per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store instruction is presented this cycle |
| st_dreg | input | 4 | Name of the register whose value is to be stored |
| st_base | input | 4 | Low address bits of the resolved base register value |
| st_imm | input | 4 | Low address bits of the immediate offset |
| rf_raddr | output | 4 | Register file read address for the firing store |
| rf_rdata | input | 16 | Register file read data for `rf_raddr` |
| mem_we | output | 1 | A data memory write takes place this cycle |
| mem_waddr | output | 4 | Address of that write |
| mem_wdata | output | 16 | Value of that write |
| dbg_addr | input | 4 | Test read address |
| dbg_data | output | 16 | Data memory word at `dbg_addr` |

## Verification
Address generation for one store and the memory write of the store before it share a cycle whenever stores arrive back to back. The bench provokes this with an unbroken stream of sixteen stores at scattered addresses, checking in each cycle that the write under way carries the previous store's address and register while the next store is being taken, and then reading every word back. It also rewrites the register file between the two steps and repeats a target address, so that a read at the wrong step or a reordered queue shows as a wrong stored value.

// File: rtl/store_addr_path.sv
module store_addr_path #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int RW = 4,
  parameter int QD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [RW-1:0] st_dreg,
  input  logic [AW-1:0] st_base,
  input  logic [AW-1:0] st_imm,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int MEMN = 1 << AW;
  localparam int QW   = (QD > 1) ? $clog2(QD) : 1;

  logic [RW-1:0] q_reg [QD];
  logic [AW-1:0] q_adr [QD];
  logic [QW-1:0] wp, rp;
  logic [QW:0]   cnt;
  logic [DW-1:0] mem [MEMN];

  logic          push, pop;
  logic [AW-1:0] gen_addr;

  assign gen_addr  = st_base + st_imm;
  assign pop       = (cnt != '0);
  assign push      = st_valid && (cnt != (QW+1)'(QD) || pop);
  assign rf_raddr  = q_reg[rp];
  assign mem_we    = pop;
  assign mem_waddr = q_adr[rp];
  assign mem_wdata = rf_rdata;
  assign dbg_data  = mem[dbg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < QD; i++) begin
        q_reg[i] <= '0;
        q_adr[i] <= '0;
      end
    end else begin
      if (push) begin
        q_reg[wp] <= st_dreg;
        q_adr[wp] <= gen_addr;
        wp        <= (wp == QW'(QD-1)) ? '0 : wp + 1'b1;
      end
      if (pop)
        rp <= (rp == QW'(QD-1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[mem_waddr] <= mem_wdata;
    end
  end
endmodule

module store_addr_path_chk #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic [RW-1:0] st_dreg,
  input logic [AW-1:0] st_base,
  input logic [AW-1:0] st_imm,
  input logic [RW-1:0] rf_raddr,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] dbg_addr,
  input logic [DW-1:0] dbg_data
);
  a_r4_write_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> mem_we);

  a_r2_addr_mod16: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> mem_waddr == AW'($past(st_base) + $past(st_imm)));

  a_r3_reg_named: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> rf_raddr == $past(st_dreg));

  a_r7_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !mem_we);

  a_r8_dbg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mem_we) && $stable(dbg_addr)) |-> $stable(dbg_data));
endmodule

bind store_addr_path store_addr_path_chk #(.DW(DW), .AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_dreg(st_dreg),
  .st_base(st_base), .st_imm(st_imm), .rf_raddr(rf_raddr), .mem_we(mem_we),
  .mem_waddr(mem_waddr), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
);

// File: tb/tb_store_addr_path.sv
module tb_store_addr_path;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        st_valid = 0;
  logic [3:0]  st_dreg = 0, st_base = 0, st_imm = 0, dbg_addr = 0;
  logic [3:0]  rf_raddr, mem_waddr;
  logic [15:0] rf_rdata, mem_wdata, dbg_data;
  logic        mem_we;

  logic [15:0] rf [16];
  logic [15:0] model [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign rf_rdata = rf[rf_raddr];

  store_addr_path dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_dreg(st_dreg),
    .st_base(st_base), .st_imm(st_imm), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 16; a++) begin
      dbg_addr = 4'(a);
      #1;
      check(dbg_data == model[a], req, dbg_data, model[a]);
    end
  endtask

  initial begin
    for (int r = 0; r < 16; r++) begin
      rf[r] = 16'hA000 + 16'(r * 37);
      model[r] = 0;
    end
    repeat (3) @(negedge clk);
    check(mem_we == 0, "R1 no write in reset", mem_we, 0);
    rst_n = 1;
    @(negedge clk);
    check(mem_we == 0, "R1 idle after reset", mem_we, 0);
    read_all("R1 memory cleared");

    // Sweep every base/offset pair; change the register between the steps.
    for (int b = 0; b < 16; b++) begin
      for (int i = 0; i < 16; i++) begin
        logic [3:0] dr, ea;
        dr = 4'((b * 3 + i) % 16);
        ea = 4'((b + i) % 16);
        st_valid = 1; st_dreg = dr; st_base = 4'(b); st_imm = 4'(i);
        @(negedge clk);
        st_valid = 0;
        check(mem_we == 1, "R4 write one cycle later", mem_we, 1);
        check(mem_waddr == ea, "R2 address mod 16", mem_waddr, ea);
        check(rf_raddr == dr, "R3 register named", rf_raddr, dr);
        rf[dr] = rf[dr] + 16'h0101;
        model[ea] = rf[dr];
        #1;
        check(mem_wdata == rf[dr], "R3 value read at store step", mem_wdata, rf[dr]);
        @(negedge clk);
        dbg_addr = ea;
        #1;
        check(dbg_data == model[ea], "R8 readback of stored word", dbg_data, model[ea]);
      end
    end

    // st_valid low with live-looking fields: nothing written.
    st_valid = 0; st_dreg = 4'd5; st_base = 4'd7; st_imm = 4'd2;
    @(negedge clk);
    check(mem_we == 0, "R6 no store without valid", mem_we, 0);
    @(negedge clk);
    check(mem_we == 0, "R7 no write when queue empty", mem_we, 0);
    read_all("R6 memory unchanged");

    // Back-to-back stream: accept and write in the same cycle.
    for (int k = 0; k <= 16; k++) begin
      if (k < 16) begin
        st_valid = 1; st_dreg = 4'((k * 7) % 16);
        st_base = 4'((k * 5) % 16); st_imm = 4'(k);
      end else st_valid = 0;
      if (k > 0) begin
        logic [3:0] pa, pr;
        pa = 4'(((k - 1) * 5 + (k - 1)) % 16);
        pr = 4'(((k - 1) * 7) % 16);
        check(mem_we == 1, "R9 write during next accept", mem_we, 1);
        check(mem_waddr == pa, "R9 streamed address", mem_waddr, pa);
        check(rf_raddr == pr, "R9 streamed register", rf_raddr, pr);
        model[pa] = rf[pr];
      end
      @(negedge clk);
    end
    check(mem_we == 0, "R7 stream drained", mem_we, 0);
    read_all("R9 stream results");

    // Two stores to one address, consecutive: later value stays.
    st_valid = 1; st_dreg = 4'd1; st_base = 4'd9; st_imm = 4'd9;
    @(negedge clk);
    st_dreg = 4'd2; st_base = 4'd15; st_imm = 4'd3;
    @(negedge clk);
    st_valid = 0;
    model[2] = rf[2];
    @(negedge clk);
    dbg_addr = 4'd2;
    #1;
    check(dbg_data == rf[2], "R5 later store wins", dbg_data, rf[2]);
    read_all("R5 memory image");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule